// File: doc/BRIEF.md
# PLL Reconfiguration Sequencer

This block is a hardware state machine that reprograms a clock generator built from a PLL and its post-dividers. It replaces a firmware routine. After a one-cycle start pulse it captures its whole configuration and then drives the generator's control pins in a fixed order. First it opens register access and moves the downstream clock onto the bypass path. It then shuts down the post-dividers and the PLL, holds the post-dividers in reset, and loads the new divider, multiplier, pre-divider and miscellaneous values. Finally it restarts the PLL, waits for lock, and hands the clock back to the PLL output before closing register access again.

Seven settle waits sit between the stages, and each one has its own programmable cycle count. The wait after the PLL is switched off has a floor of `CLK_MHZ` cycles, which is one microsecond at the stated clock rate. If the target is the primary PLL, the block also pulses a configuration strobe for a top-level clock controller at three fixed points. The lock wait has a programmable timeout. When it expires, the block keeps the bypass selected, turns the PLL back off, closes register access and pulses an error flag instead of done. All control and status pins are plain levels or pulses. There is no streaming data path.

Top module: `pll_reseq_top`

## Requirements
- R1: After synchronous reset `rst`, the outputs are as follows. `regs_unlock_o`=0. `bypass_sel_o`=1, where 1 selects the bypass reference and 0 passes the PLL output. `pll_en_o`=0. `pdiv_en_o`=0. `pdiv_rst_o`=1. `pdiv_sync_dis_o`=1. `busy_o`, `done_o` and `lock_err_o` are all 0.
- R2: Every configuration input, including `primary_i`, is captured on the clock edge that samples `start_i` high while the block is idle. `busy_o` is high from that edge until the edge that raises `done_o` or `lock_err_o`. A start pulse while busy, and any configuration change after capture, have no effect on timing or on the loaded values.
- R3: With start sampled on edge s, `regs_unlock_o` rises on edge s+1 and `bypass_sel_o` rises on edge s+2.
- R4: The teardown runs in this order. The post-dividers are disabled `d0`+2 edges after the bypass edge. The PLL is disabled `d1`+2 edges after that. Delay field j sits at bits [j*DLY_W +: DLY_W] of `dly_cfg_i`. The wait after j=0 follows the bypass step, j=1 follows post-divider disable, j=2 follows PLL disable, j=3 follows sync-disable clear, j=4 follows the miscellaneous load, j=5 follows post-divider enable, and j=6 follows the pass-through step.
- R5: Post-divider reset and sync-disable both assert max(`d2`, `CLK_MHZ`)+2 edges after PLL disable, so that wait is never shorter than one microsecond.
- R6: The reprogram runs in this order. The post-divider value loads one edge after the reset edge. Sync-disable clears on the next edge. The post-divider reset releases `d3`+2 edges later. The multiplier, pre-divider and miscellaneous values load on the next three edges. `pll_en_o` rises `d4`+5 edges after the reset release. The loaded values equal the captured ones.
- R7: If `pll_lock_i` is sampled high on any of the first T+1 edges after the edge that raised `pll_en_o` (T = `lock_to_i`), then `pdiv_en_o` rises on the following edge.
- R8: `bypass_sel_o` falls `d5`+2 edges after the post-divider enable. `regs_unlock_o` falls and `done_o` pulses `d6`+3 edges after the bypass falls.
- R9: If `primary_i` was captured as 1, `clkctl_cfg_stb_o` gives single-cycle pulses on three edges: the unlock edge, the post-divider reset edge, and the edge before relock. If it was captured as 0, there are no pulses.
- R10: If lock is not sampled in the R7 window, then T+2 edges after `pll_en_o` rose, `lock_err_o` pulses, `pll_en_o` and `regs_unlock_o` fall, `bypass_sel_o` stays 1, and `done_o` does not pulse.
- R11: `done_o` and `lock_err_o` are single-cycle pulses, never high together, and exactly one of them ends each run.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, frequency `CLK_MHZ` MHz |
| rst | input | 1 | Synchronous reset, active high |
| start_i | input | 1 | Start pulse, honoured only when idle |
| primary_i | input | 1 | Target is the primary PLL; enables controller strobes |
| pll_lock_i | input | 1 | Lock indication from the PLL, synchronous to `clk` |
| dly_cfg_i | input | 7*DLY_W | Seven settle wait lengths in cycles |
| lock_to_i | input | TO_W | Lock timeout T |
| mult_cfg_i | input | MULT_W | New feedback multiplier |
| prediv_cfg_i | input | PREDIV_W | New PLL input divider |
| pdiv_cfg_i | input | PDIV_W | New post-divider value |
| misc_cfg_i | input | MISC_W | New miscellaneous PLL controls |
| regs_unlock_o | output | 1 | PLL register access open |
| bypass_sel_o | output | 1 | 1 selects bypass reference, 0 passes PLL output |
| pdiv_en_o | output | 1 | Post-divider enable |
| pdiv_rst_o | output | 1 | Post-divider reset |
| pdiv_sync_dis_o | output | 1 | Post-divider sync-disable |
| pll_en_o | output | 1 | PLL enable |
| pll_mult_o | output | MULT_W | Applied multiplier |
| pll_prediv_o | output | PREDIV_W | Applied input divider |
| pdiv_val_o | output | PDIV_W | Applied post-divider value |
| pll_misc_o | output | MISC_W | Applied miscellaneous controls |
| clkctl_cfg_stb_o | output | 1 | Clock-controller configuration strobe |
| busy_o | output | 1 | Sequence in progress |
| done_o | output | 1 | One-cycle pulse: sequence completed |
| lock_err_o | output | 1 | One-cycle pulse: lock timeout |

## Verification
The assertions rely on three assumptions about the inputs:
- `pll_lock_i` is already synchronous to `clk`.
- `DLY_W` is wide enough to hold `CLK_MHZ`.
- `start_i` is a one-cycle pulse.

Under these assumptions they can treat the lock window and the post-disable floor as exact cycle counts. The stimulus keeps within them. The bench drives every input at the falling edge and sizes the delay fields above `CLK_MHZ`. It raises lock only a fixed number of cycles after it sees `pll_en_o` rise, and it lowers lock again before each start. A stray start pulse and a configuration change are injected only while the block is already busy.

// File: rtl/pll_reseq_pkg.sv
package pll_reseq_pkg;

  localparam int NUM_SETTLE = 7;

  // settle slot indices (order of use in the sequence)
  localparam int SL_BYPASS  = 0;
  localparam int SL_PDOFF   = 1;
  localparam int SL_PLLOFF  = 2;
  localparam int SL_SYNCCLR = 3;
  localparam int SL_MISC    = 4;
  localparam int SL_PDON    = 5;
  localparam int SL_PASS    = 6;

  typedef enum logic [4:0] {
    ST_IDLE,
    ST_UNLOCK,
    ST_BYPASS,
    ST_PD_OFF,
    ST_PLL_OFF,
    ST_PD_RST,
    ST_PD_LOAD,
    ST_SYNC_CLR,
    ST_PD_REL,
    ST_MULT,
    ST_DIV,
    ST_MISC,
    ST_PLL_ON,
    ST_LOCK_WAIT,
    ST_PD_ON,
    ST_PASS,
    ST_FIN_CFG,
    ST_RELOCK,
    ST_FAIL,
    ST_SETTLE
  } seq_state_e;

endpackage

// File: rtl/settle_timer.sv
module settle_timer #(
  parameter int W = 12
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load_i,
  input  logic [W-1:0] len_i,
  output logic         expired_o
);

  logic [W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
    end else if (load_i) begin
      cnt_q <= len_i;
    end else if (cnt_q != '0) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  assign expired_o = (cnt_q == '0);

endmodule

// File: rtl/lock_watch.sv
module lock_watch #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         arm_i,
  input  logic         lock_i,
  input  logic [W-1:0] limit_i,
  output logic         locked_o,
  output logic         timeout_o
);

  logic [W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst || !arm_i) begin
      cnt_q <= '0;
    end else if (!lock_i && cnt_q != limit_i) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign locked_o  = arm_i && lock_i;
  assign timeout_o = arm_i && !lock_i && (cnt_q == limit_i);

  // R7
  wait_window_chk: assert property (@(posedge clk) disable iff (rst)
    arm_i |-> (cnt_q <= limit_i));

endmodule

// File: rtl/reseq_fsm.sv
module reseq_fsm
  import pll_reseq_pkg::*;
#(
  parameter int CLK_MHZ  = 100,
  parameter int DLY_W    = 12,
  parameter int TO_W     = 16,
  parameter int MULT_W   = 12,
  parameter int PREDIV_W = 6,
  parameter int PDIV_W   = 7,
  parameter int MISC_W   = 8,
  localparam int DLY_BUS_W = NUM_SETTLE * DLY_W
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 start_i,
  input  logic                 primary_i,
  input  logic [DLY_BUS_W-1:0] dly_cfg_i,
  input  logic [TO_W-1:0]      lock_to_i,
  input  logic [MULT_W-1:0]    mult_cfg_i,
  input  logic [PREDIV_W-1:0]  prediv_cfg_i,
  input  logic [PDIV_W-1:0]    pdiv_cfg_i,
  input  logic [MISC_W-1:0]    misc_cfg_i,
  output logic                 tmr_load_o,
  output logic [DLY_W-1:0]     tmr_len_o,
  input  logic                 tmr_expired_i,
  output logic                 lw_arm_o,
  output logic [TO_W-1:0]      lw_limit_o,
  input  logic                 lw_locked_i,
  input  logic                 lw_timeout_i,
  output logic                 regs_unlock_o,
  output logic                 bypass_sel_o,
  output logic                 pdiv_en_o,
  output logic                 pdiv_rst_o,
  output logic                 pdiv_sync_dis_o,
  output logic                 pll_en_o,
  output logic [MULT_W-1:0]    pll_mult_o,
  output logic [PREDIV_W-1:0]  pll_prediv_o,
  output logic [PDIV_W-1:0]    pdiv_val_o,
  output logic [MISC_W-1:0]    pll_misc_o,
  output logic                 clkctl_cfg_stb_o,
  output logic                 busy_o,
  output logic                 done_o,
  output logic                 lock_err_o
);

  localparam logic [DLY_W-1:0] MIN_PD_CYC = DLY_W'(CLK_MHZ);
  localparam int GAP_W = $clog2(CLK_MHZ + 3) + 1;
  localparam logic [GAP_W-1:0] GAP_SAT = GAP_W'(CLK_MHZ + 2);

  seq_state_e state_q, ret_q;

  // captured configuration
  logic [DLY_W-1:0]    dly_in [NUM_SETTLE];
  logic [DLY_W-1:0]    dly_q  [NUM_SETTLE];
  logic                prim_q;
  logic [TO_W-1:0]     to_q;
  logic [MULT_W-1:0]   mult_q;
  logic [PREDIV_W-1:0] prediv_q;
  logic [PDIV_W-1:0]   pdiv_q;
  logic [MISC_W-1:0]   misc_q;

  // output registers
  logic                unlock_q, bypass_q, pd_en_q, pd_rst_q, sync_dis_q, pll_en_q;
  logic [MULT_W-1:0]   mult_out_q;
  logic [PREDIV_W-1:0] prediv_out_q;
  logic [PDIV_W-1:0]   pdiv_out_q;
  logic [MISC_W-1:0]   misc_out_q;
  logic                stb_q, done_q, err_q;

  for (genvar g = 0; g < NUM_SETTLE; g++) begin : g_unpack
    assign dly_in[g] = dly_cfg_i[g*DLY_W +: DLY_W];
  end

  logic [DLY_W-1:0] pd_off_len;
  assign pd_off_len = (dly_q[SL_PLLOFF] < MIN_PD_CYC) ? MIN_PD_CYC : dly_q[SL_PLLOFF];

  // settle timer load: issued by every step that is followed by a wait
  always_comb begin
    tmr_load_o = 1'b1;
    tmr_len_o  = '0;
    unique case (state_q)
      ST_BYPASS:   tmr_len_o = dly_q[SL_BYPASS];
      ST_PD_OFF:   tmr_len_o = dly_q[SL_PDOFF];
      ST_PLL_OFF:  tmr_len_o = pd_off_len;
      ST_SYNC_CLR: tmr_len_o = dly_q[SL_SYNCCLR];
      ST_MISC:     tmr_len_o = dly_q[SL_MISC];
      ST_PD_ON:    tmr_len_o = dly_q[SL_PDON];
      ST_PASS:     tmr_len_o = dly_q[SL_PASS];
      default:     tmr_load_o = 1'b0;
    endcase
  end

  assign lw_arm_o   = (state_q == ST_LOCK_WAIT);
  assign lw_limit_o = to_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q      <= ST_IDLE;
      ret_q        <= ST_IDLE;
      for (int i = 0; i < NUM_SETTLE; i++) dly_q[i] <= '0;
      prim_q       <= 1'b0;
      to_q         <= '0;
      mult_q       <= '0;
      prediv_q     <= '0;
      pdiv_q       <= '0;
      misc_q       <= '0;
      unlock_q     <= 1'b0;
      bypass_q     <= 1'b1;
      pd_en_q      <= 1'b0;
      pd_rst_q     <= 1'b1;
      sync_dis_q   <= 1'b1;
      pll_en_q     <= 1'b0;
      mult_out_q   <= '0;
      prediv_out_q <= '0;
      pdiv_out_q   <= '0;
      misc_out_q   <= '0;
      stb_q        <= 1'b0;
      done_q       <= 1'b0;
      err_q        <= 1'b0;
    end else begin
      stb_q  <= 1'b0;
      done_q <= 1'b0;
      err_q  <= 1'b0;
      unique case (state_q)
        ST_IDLE: begin
          if (start_i) begin
            for (int i = 0; i < NUM_SETTLE; i++) dly_q[i] <= dly_in[i];
            prim_q   <= primary_i;
            to_q     <= lock_to_i;
            mult_q   <= mult_cfg_i;
            prediv_q <= prediv_cfg_i;
            pdiv_q   <= pdiv_cfg_i;
            misc_q   <= misc_cfg_i;
            state_q  <= ST_UNLOCK;
          end
        end
        ST_UNLOCK: begin
          unlock_q <= 1'b1;
          stb_q    <= prim_q;
          state_q  <= ST_BYPASS;
        end
        ST_BYPASS: begin
          bypass_q <= 1'b1;
          ret_q    <= ST_PD_OFF;
          state_q  <= ST_SETTLE;
        end
        ST_PD_OFF: begin
          pd_en_q <= 1'b0;
          ret_q   <= ST_PLL_OFF;
          state_q <= ST_SETTLE;
        end
        ST_PLL_OFF: begin
          pll_en_q <= 1'b0;
          ret_q    <= ST_PD_RST;
          state_q  <= ST_SETTLE;
        end
        ST_PD_RST: begin
          pd_rst_q   <= 1'b1;
          sync_dis_q <= 1'b1;
          stb_q      <= prim_q;
          state_q    <= ST_PD_LOAD;
        end
        ST_PD_LOAD: begin
          pdiv_out_q <= pdiv_q;
          state_q    <= ST_SYNC_CLR;
        end
        ST_SYNC_CLR: begin
          sync_dis_q <= 1'b0;
          ret_q      <= ST_PD_REL;
          state_q    <= ST_SETTLE;
        end
        ST_PD_REL: begin
          pd_rst_q <= 1'b0;
          state_q  <= ST_MULT;
        end
        ST_MULT: begin
          mult_out_q <= mult_q;
          state_q    <= ST_DIV;
        end
        ST_DIV: begin
          prediv_out_q <= prediv_q;
          state_q      <= ST_MISC;
        end
        ST_MISC: begin
          misc_out_q <= misc_q;
          ret_q      <= ST_PLL_ON;
          state_q    <= ST_SETTLE;
        end
        ST_PLL_ON: begin
          pll_en_q <= 1'b1;
          state_q  <= ST_LOCK_WAIT;
        end
        ST_LOCK_WAIT: begin
          if (lw_locked_i) begin
            state_q <= ST_PD_ON;
          end else if (lw_timeout_i) begin
            state_q <= ST_FAIL;
          end
        end
        ST_PD_ON: begin
          pd_en_q <= 1'b1;
          ret_q   <= ST_PASS;
          state_q <= ST_SETTLE;
        end
        ST_PASS: begin
          bypass_q <= 1'b0;
          ret_q    <= ST_FIN_CFG;
          state_q  <= ST_SETTLE;
        end
        ST_FIN_CFG: begin
          stb_q   <= prim_q;
          state_q <= ST_RELOCK;
        end
        ST_RELOCK: begin
          unlock_q <= 1'b0;
          done_q   <= 1'b1;
          state_q  <= ST_IDLE;
        end
        ST_FAIL: begin
          pll_en_q <= 1'b0;
          bypass_q <= 1'b1;
          unlock_q <= 1'b0;
          err_q    <= 1'b1;
          state_q  <= ST_IDLE;
        end
        ST_SETTLE: begin
          if (tmr_expired_i) state_q <= ret_q;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign regs_unlock_o    = unlock_q;
  assign bypass_sel_o     = bypass_q;
  assign pdiv_en_o        = pd_en_q;
  assign pdiv_rst_o       = pd_rst_q;
  assign pdiv_sync_dis_o  = sync_dis_q;
  assign pll_en_o         = pll_en_q;
  assign pll_mult_o       = mult_out_q;
  assign pll_prediv_o     = prediv_out_q;
  assign pdiv_val_o       = pdiv_out_q;
  assign pll_misc_o       = misc_out_q;
  assign clkctl_cfg_stb_o = stb_q;
  assign busy_o           = (state_q != ST_IDLE);
  assign done_o           = done_q;
  assign lock_err_o       = err_q;

  // cycles since the PLL was last seen disabled, saturating
  logic [GAP_W-1:0] gap_q;
  always_ff @(posedge clk) begin
    if (rst || pll_en_q) begin
      gap_q <= '0;
    end else if (gap_q != GAP_SAT) begin
      gap_q <= gap_q + 1'b1;
    end
  end

  // R5
  pd_off_floor_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(pd_rst_q) |-> (gap_q >= GAP_W'(CLK_MHZ)));

  // R10
  pll_on_in_bypass_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(pll_en_q) |-> bypass_q);

  // R4
  pll_off_order_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(pll_en_q) |-> (bypass_q && !pd_en_q));

  // R8
  pass_release_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(bypass_q) |-> (pll_en_q && pd_en_q && unlock_q && !pd_rst_q));

  // R2
  relock_idle_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(unlock_q) |-> (state_q == ST_IDLE));

  // R11
  done_err_excl_chk: assert property (@(posedge clk) disable iff (rst)
    !(done_q && err_q));

  // R11
  done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    done_q |=> !done_q);

  // R11
  err_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    err_q |=> !err_q);

endmodule

// File: rtl/pll_reseq_top.sv
module pll_reseq_top
  import pll_reseq_pkg::*;
#(
  parameter int CLK_MHZ  = 100,
  parameter int DLY_W    = 12,
  parameter int TO_W     = 16,
  parameter int MULT_W   = 12,
  parameter int PREDIV_W = 6,
  parameter int PDIV_W   = 7,
  parameter int MISC_W   = 8,
  localparam int DLY_BUS_W = NUM_SETTLE * DLY_W
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 start_i,
  input  logic                 primary_i,
  input  logic                 pll_lock_i,
  input  logic [DLY_BUS_W-1:0] dly_cfg_i,
  input  logic [TO_W-1:0]      lock_to_i,
  input  logic [MULT_W-1:0]    mult_cfg_i,
  input  logic [PREDIV_W-1:0]  prediv_cfg_i,
  input  logic [PDIV_W-1:0]    pdiv_cfg_i,
  input  logic [MISC_W-1:0]    misc_cfg_i,
  output logic                 regs_unlock_o,
  output logic                 bypass_sel_o,
  output logic                 pdiv_en_o,
  output logic                 pdiv_rst_o,
  output logic                 pdiv_sync_dis_o,
  output logic                 pll_en_o,
  output logic [MULT_W-1:0]    pll_mult_o,
  output logic [PREDIV_W-1:0]  pll_prediv_o,
  output logic [PDIV_W-1:0]    pdiv_val_o,
  output logic [MISC_W-1:0]    pll_misc_o,
  output logic                 clkctl_cfg_stb_o,
  output logic                 busy_o,
  output logic                 done_o,
  output logic                 lock_err_o
);

  logic             tmr_load, tmr_expired;
  logic [DLY_W-1:0] tmr_len;
  logic             lw_arm, lw_locked, lw_timeout;
  logic [TO_W-1:0]  lw_limit;

  settle_timer #(.W(DLY_W)) u_timer (
    .clk       (clk),
    .rst       (rst),
    .load_i    (tmr_load),
    .len_i     (tmr_len),
    .expired_o (tmr_expired)
  );

  lock_watch #(.W(TO_W)) u_lock (
    .clk       (clk),
    .rst       (rst),
    .arm_i     (lw_arm),
    .lock_i    (pll_lock_i),
    .limit_i   (lw_limit),
    .locked_o  (lw_locked),
    .timeout_o (lw_timeout)
  );

  reseq_fsm #(
    .CLK_MHZ  (CLK_MHZ),
    .DLY_W    (DLY_W),
    .TO_W     (TO_W),
    .MULT_W   (MULT_W),
    .PREDIV_W (PREDIV_W),
    .PDIV_W   (PDIV_W),
    .MISC_W   (MISC_W)
  ) u_fsm (
    .clk              (clk),
    .rst              (rst),
    .start_i          (start_i),
    .primary_i        (primary_i),
    .dly_cfg_i        (dly_cfg_i),
    .lock_to_i        (lock_to_i),
    .mult_cfg_i       (mult_cfg_i),
    .prediv_cfg_i     (prediv_cfg_i),
    .pdiv_cfg_i       (pdiv_cfg_i),
    .misc_cfg_i       (misc_cfg_i),
    .tmr_load_o       (tmr_load),
    .tmr_len_o        (tmr_len),
    .tmr_expired_i    (tmr_expired),
    .lw_arm_o         (lw_arm),
    .lw_limit_o       (lw_limit),
    .lw_locked_i      (lw_locked),
    .lw_timeout_i     (lw_timeout),
    .regs_unlock_o    (regs_unlock_o),
    .bypass_sel_o     (bypass_sel_o),
    .pdiv_en_o        (pdiv_en_o),
    .pdiv_rst_o       (pdiv_rst_o),
    .pdiv_sync_dis_o  (pdiv_sync_dis_o),
    .pll_en_o         (pll_en_o),
    .pll_mult_o       (pll_mult_o),
    .pll_prediv_o     (pll_prediv_o),
    .pdiv_val_o       (pdiv_val_o),
    .pll_misc_o       (pll_misc_o),
    .clkctl_cfg_stb_o (clkctl_cfg_stb_o),
    .busy_o           (busy_o),
    .done_o           (done_o),
    .lock_err_o       (lock_err_o)
  );

endmodule

// File: tb/tb_pll_reseq_top.sv
module tb_pll_reseq_top;

  localparam int CLK_P    = 10;
  localparam int CLK_MHZ  = 3;
  localparam int DLY_W    = 4;
  localparam int TO_W     = 4;
  localparam int MULT_W   = 8;
  localparam int PREDIV_W = 6;
  localparam int PDIV_W   = 6;
  localparam int MISC_W   = 8;
  localparam int NS       = 7;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start = 1'b0, prim = 1'b0, lock = 1'b0;
  logic [NS*DLY_W-1:0] dly_cfg = '0;
  logic [TO_W-1:0]     to_cfg = '0;
  logic [MULT_W-1:0]   mult_cfg = '0;
  logic [PREDIV_W-1:0] prediv_cfg = '0;
  logic [PDIV_W-1:0]   pdiv_cfg = '0;
  logic [MISC_W-1:0]   misc_cfg = '0;
  logic unl, byp, pde, pdr, syd, plle, stb, busy, done, err;
  logic [MULT_W-1:0]   mult_o;
  logic [PREDIV_W-1:0] prediv_o;
  logic [PDIV_W-1:0]   pdiv_o;
  logic [MISC_W-1:0]   misc_o;

  always #(CLK_P/2) clk = ~clk;

  pll_reseq_top #(
    .CLK_MHZ(CLK_MHZ), .DLY_W(DLY_W), .TO_W(TO_W), .MULT_W(MULT_W),
    .PREDIV_W(PREDIV_W), .PDIV_W(PDIV_W), .MISC_W(MISC_W)
  ) dut (
    .clk(clk), .rst(rst), .start_i(start), .primary_i(prim), .pll_lock_i(lock),
    .dly_cfg_i(dly_cfg), .lock_to_i(to_cfg), .mult_cfg_i(mult_cfg),
    .prediv_cfg_i(prediv_cfg), .pdiv_cfg_i(pdiv_cfg), .misc_cfg_i(misc_cfg),
    .regs_unlock_o(unl), .bypass_sel_o(byp), .pdiv_en_o(pde), .pdiv_rst_o(pdr),
    .pdiv_sync_dis_o(syd), .pll_en_o(plle), .pll_mult_o(mult_o),
    .pll_prediv_o(prediv_o), .pdiv_val_o(pdiv_o), .pll_misc_o(misc_o),
    .clkctl_cfg_stb_o(stb), .busy_o(busy), .done_o(done), .lock_err_o(err)
  );

  int n_chk = 0, n_err = 0, cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input string req, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // event monitor, sampled at the falling edge
  int t_unl_r, t_unl_f, t_byp_r, t_byp_f, t_pde_f, t_pde_r, t_pll_f, t_pll_fl, t_pll_r;
  int t_rst_r, t_rst_f, t_syd_f, t_done, t_err, n_done, n_errp, n_stb, busy_gap;
  int stb_t [3];
  int lat, lk_cnt;
  bit lk_arm, busy_track;
  logic p_unl, p_byp, p_pde, p_pdr, p_syd, p_pll;

  task automatic clear_mon();
    t_unl_r = -1; t_unl_f = -1; t_byp_r = -1; t_byp_f = -1; t_pde_f = -1;
    t_pde_r = -1; t_pll_f = -1; t_pll_fl = -1; t_pll_r = -1; t_rst_r = -1;
    t_rst_f = -1; t_syd_f = -1; t_done = -1; t_err = -1;
    n_done = 0; n_errp = 0; n_stb = 0; busy_gap = 0;
    for (int i = 0; i < 3; i++) stb_t[i] = -1;
    lk_arm = 0;
  endtask

  always @(negedge clk) begin
    if (!rst) begin
      if (unl && !p_unl) t_unl_r = cyc;
      if (!unl && p_unl) t_unl_f = cyc;
      if (byp && !p_byp) t_byp_r = cyc;
      if (!byp && p_byp) t_byp_f = cyc;
      if (!pde && p_pde && t_pde_f < 0) t_pde_f = cyc;
      if (pde && !p_pde) t_pde_r = cyc;
      if (!plle && p_pll) begin
        if (t_pll_f < 0) t_pll_f = cyc;
        t_pll_fl = cyc;
      end
      if (pdr && !p_pdr) t_rst_r = cyc;
      if (!pdr && p_pdr) t_rst_f = cyc;
      if (!syd && p_syd) t_syd_f = cyc;
      if (stb) begin
        if (n_stb < 3) stb_t[n_stb] = cyc;
        n_stb++;
      end
      if (done) begin n_done++; t_done = cyc; end
      if (err) begin n_errp++; t_err = cyc; end
      if (busy_track && !busy && !done && !err) busy_gap++;
      if (done || err) busy_track = 0;
      if (plle && !p_pll) begin
        t_pll_r = cyc;
        if (lat >= 0) begin lk_arm = 1; lk_cnt = lat; end
      end
      if (lk_arm) begin
        if (lk_cnt == 0) begin lock = 1'b1; lk_arm = 0; end
        else lk_cnt--;
      end
    end
    p_unl = unl; p_byp = byp; p_pde = pde; p_pdr = pdr; p_syd = syd; p_pll = plle;
  end

  int run_id = 0;

  // mode: 0 full, 1 previous run ended in error, 2 first run after reset
  task automatic run_seq(input int dl[NS], input bit pr, input int L, input int T,
                         input int mode, input bit inject);
    int s, k, d2e, e_pdef, e_pllf, e_rstr, e_syf, e_rstf, e_pllr, e_pder, e_bypf, e_unlf, e_err;
    int exp_mult, exp_pre, exp_pd, exp_misc;
    bit ok;
    run_id++;
    for (int j = 0; j < NS; j++) dly_cfg[j*DLY_W +: DLY_W] = DLY_W'(dl[j]);
    to_cfg = TO_W'(T);
    prim = pr;
    exp_mult = (run_id * 37 + 5) % 256;
    exp_pre  = (run_id * 11 + 3) % 64;
    exp_pd   = (run_id * 7 + 1) % 64;
    exp_misc = (run_id * 53 + 9) % 256;
    mult_cfg = MULT_W'(exp_mult); prediv_cfg = PREDIV_W'(exp_pre);
    pdiv_cfg = PDIV_W'(exp_pd);   misc_cfg = MISC_W'(exp_misc);
    lock = 1'b0;
    lat = L;
    clear_mon();
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    s = cyc;
    busy_track = 1;
    chk("R2", "busy after start", int'(busy), 1);
    if (inject) begin
      repeat (4) @(negedge clk);
      start = 1'b1; prim = ~pr;
      mult_cfg = ~mult_cfg; pdiv_cfg = ~pdiv_cfg;
      @(negedge clk); start = 1'b0;
    end
    k = 0;
    while (t_done < 0 && t_err < 0 && k < 600) begin @(negedge clk); k++; end
    if (k >= 600) chk("R11", "run finished", 0, 1);
    repeat (3) @(negedge clk);

    d2e    = (dl[2] < CLK_MHZ) ? CLK_MHZ : dl[2];
    e_pdef = s + 4 + dl[0];
    e_pllf = e_pdef + dl[1] + 2;
    e_rstr = e_pllf + d2e + 2;
    e_syf  = e_rstr + 2;
    e_rstf = e_syf + dl[3] + 2;
    e_pllr = e_rstf + dl[4] + 5;
    ok     = (L >= 0) && (L <= T);

    chk("R3", "unlock rise", t_unl_r, s + 1);
    if (mode == 0) begin
      chk("R3", "bypass rise", t_byp_r, s + 2);
      chk("R4", "pdiv disable", t_pde_f, e_pdef);
      chk("R4", "pll disable", t_pll_f, e_pllf);
    end
    if (mode != 2) chk("R5", "pdiv reset after pll off", t_rst_r, e_rstr);
    chk("R6", "sync-disable clear", t_syd_f, e_syf);
    chk("R6", "pdiv reset release", t_rst_f, e_rstf);
    chk("R6", "pll enable", t_pll_r, e_pllr);
    chk("R2", "busy continuous", busy_gap, 0);
    chk("R2", "idle after end", int'(busy), 0);
    if (ok) begin
      e_pder = e_pllr + L + 2;
      e_bypf = e_pder + dl[5] + 2;
      e_unlf = e_bypf + dl[6] + 3;
      chk("R7", "pdiv enable after lock", t_pde_r, e_pder);
      chk("R8", "bypass release", t_byp_f, e_bypf);
      chk("R8", "relock", t_unl_f, e_unlf);
      chk("R8", "done time", t_done, e_unlf);
      chk("R11", "done pulses", n_done, 1);
      chk("R11", "err pulses", n_errp, 0);
      chk("R6", "mult", int'(mult_o), exp_mult);
      chk("R6", "prediv", int'(prediv_o), exp_pre);
      chk("R6", "pdiv value", int'(pdiv_o), exp_pd);
      chk("R6", "misc", int'(misc_o), exp_misc);
      chk("R9", "strobe count", n_stb, pr ? 3 : 0);
      if (pr) begin
        chk("R9", "strobe at unlock", stb_t[0], s + 1);
        chk("R9", "strobe at pdiv reset", stb_t[1], e_rstr);
        chk("R9", "strobe before relock", stb_t[2], e_unlf - 1);
      end
      chk("R8", "final bypass", int'(byp), 0);
      chk("R8", "final pll enable", int'(plle), 1);
    end else begin
      e_err = e_pllr + T + 2;
      chk("R10", "error time", t_err, e_err);
      chk("R10", "pll off at error", t_pll_fl, e_err);
      chk("R10", "relock at error", t_unl_f, e_err);
      chk("R10", "bypass kept", int'(byp), 1);
      chk("R10", "pll off", int'(plle), 0);
      chk("R10", "pdiv still off", int'(pde), 0);
      chk("R10", "no done", n_done, 0);
      chk("R11", "err pulses", n_errp, 1);
      chk("R9", "strobe count on error", n_stb, pr ? 2 : 0);
    end
  endtask

  initial begin
    #(CLK_P * 150000);
    n_err++; n_chk++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    int base [NS];
    int dl [NS];
    base = '{1, 0, 2, 1, 0, 2, 1};
    lat = -1;
    clear_mon();
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk("R1", "unlock", int'(unl), 0);
    chk("R1", "bypass", int'(byp), 1);
    chk("R1", "pll enable", int'(plle), 0);
    chk("R1", "pdiv enable", int'(pde), 0);
    chk("R1", "pdiv reset", int'(pdr), 1);
    chk("R1", "sync-disable", int'(syd), 1);
    chk("R1", "busy", int'(busy), 0);
    chk("R1", "done", int'(done), 0);
    chk("R1", "err", int'(err), 0);

    run_seq(base, 1'b1, 0, 5, 2, 1'b0);

    // sweep each settle slot over a range of lengths
    for (int j = 0; j < NS; j++) begin
      foreach (dl[i]) dl[i] = base[i];
      for (int vi = 0; vi < 4; vi++) begin
        int v;
        v = (vi == 3) ? 7 : ((vi == 2) ? 3 : vi);
        dl[j] = v;
        run_seq(dl, v[0], (j + v) % 4, 5, 0, 1'b0);
      end
    end

    // lock latency sweep up to the window edge (R7)
    for (int l = 0; l <= 3; l++) run_seq(base, l[0], l, 3, 0, 1'b0);

    // timeout: lock one cycle late, and lock never (R10)
    for (int ti = 0; ti < 3; ti++) begin
      int t;
      t = ti * 3;
      run_seq(base, ti[0], t + 1, t, 0, 1'b0);
      run_seq(base, 1'b1, 0, 4, 1, 1'b0);
      run_seq(base, 1'b1, -1, t, 0, 1'b0);
      run_seq(base, 1'b0, 1, 4, 1, 1'b0);
    end

    // start while busy and config changes after capture are ignored (R2)
    run_seq(base, 1'b1, 2, 5, 0, 1'b1);
    run_seq(base, 1'b0, 1, 5, 0, 1'b1);

    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

endmodule